// File: doc/BRIEF.md
# Gated-Reset Dual Byte FIFO Bridge

This block sits between a host bus and the data port of a serial communications controller. It holds two independent byte queues. The outbound queue takes bytes the host writes and hands them to the controller side. The inbound queue takes bytes the controller side delivers and hands them to the host. A small host-visible register set enables the queues and can flush either queue. A read-only flag word reports the live fill state of both queues.

The host sees four addresses. Address 0 is the data port. While the queues are enabled, the data port is routed into the queues. While they are disabled, it is routed straight to the controller's data register. Address 1 is the controller's control port, and it always passes straight through. Address 2 is the queue control register and address 3 is the flag word. Flushing is deliberately locked out while the queues are enabled. This keeps a stray write from discarding data that is in flight.

Top module: `dual_fifo_bridge`

## Requirements
- R1: After a synchronous reset, the control register (address 2) reads 0x00, so the queues are disabled. The flag word (address 3) reads 0x09, meaning both queues are empty and neither is half-full or full.
- R2: Control bit 1 flushes the outbound queue when bit 0 (enable) is 0. The outbound empty flag (flag bit 0) is set from the second clock edge after the register write. The inbound queue keeps its contents.
- R3: Control bit 2 flushes the inbound queue when enable is 0. The inbound empty flag (flag bit 3) is set from the second clock edge after the register write. The outbound queue keeps its contents.
- R4: While enable (control bit 0) is 1, flush bits 1 and 2 have no effect on either queue's contents.
- R5: Flag word layout: bit 0 out-empty, bit 1 out-full, bit 2 out-half, bit 3 in-empty, bit 4 in-full, bit 5 in-half. The bits above 5 read 0. Half means an occupancy of 8 or more, and full means an occupancy of 16. Host writes to address 3 change nothing.
- R6: With enable at 1, host writes to address 0 enter the outbound queue and raise no controller data strobe. The controller side receives those bytes in order on `tx_head`/`tx_pop`.
- R7: With enable at 1, host reads of address 0 return the inbound bytes in arrival order and raise no controller data strobe.
- R8: A write to a full queue is dropped. A read from an empty queue returns the last byte that was read and leaves the queue unchanged.
- R9: With enable at 0, host accesses to address 0 pulse `sc_data_wr` or `sc_data_rd` in the same cycle and carry the data directly. Neither queue is touched.
- R10: Host accesses to address 1 always pulse `sc_ctl_wr` or `sc_ctl_rd`, whatever the enable state, and never touch either queue.
- R11: Writes to the control register, flush writes included, never raise any controller strobe.
- R12: While a flush bit is held at 1 with enable at 0, that queue stays empty and ignores pushes. Once the bit is cleared, the queue accepts data again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset (power-up or insertion) |
| host_addr | input | 2 | Host register select: 0 data, 1 controller control, 2 queue control, 3 flags |
| host_wr | input | 1 | Host write strobe, one cycle per access |
| host_rd | input | 1 | Host read strobe, one cycle per access |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data, combinational from host_addr |
| sc_data_wr | output | 1 | Write strobe to the controller's data register |
| sc_data_rd | output | 1 | Read strobe to the controller's data register |
| sc_ctl_wr | output | 1 | Write strobe to the controller's control port |
| sc_ctl_rd | output | 1 | Read strobe to the controller's control port |
| sc_wdata | output | 8 | Write data toward the controller |
| sc_data_rdata | input | 8 | Read data from the controller's data register |
| sc_ctl_rdata | input | 8 | Read data from the controller's control port |
| tx_pop | input | 1 | Controller side takes the outbound head byte |
| tx_head | output | 8 | Outbound head byte |
| tx_valid | output | 1 | Outbound queue holds at least one byte |
| rx_push | input | 1 | Controller side delivers an inbound byte |
| rx_wdata | input | 8 | Inbound byte |
| rx_ready | output | 1 | Inbound queue has room |

## Verification
The queues are driven with short ordered bursts of three bytes each way. These show whether the data-port steering and the byte order are right, and whether the controller strobes stay quiet while the queues are enabled. A fill of sixteen bytes followed by one extra byte separates the half-full threshold from the full threshold and proves that an overflow byte is dropped rather than written over the tail. Reads past empty distinguish a held last byte from a moved pointer. A later push then confirms that the pointers did not advance. Flush writes are issued with enable both set and clear, one queue at a time. This tells a gated flush from an ungated one and one queue's flush from the other's. Holding a flush bit while bytes arrive shows that the flush acts on the level of the bit, not on a single pulse.

// File: rtl/dfifo_pkg.sv
`timescale 1ns/1ps
// Shared definitions for the dual byte FIFO bridge: host register map
// and control-register bit positions.
package dfifo_pkg;

    // Host register select codes
    typedef enum logic [1:0] {
        HREG_DATA  = 2'd0,
        HREG_SCCTL = 2'd1,
        HREG_QCTL  = 2'd2,
        HREG_FLAGS = 2'd3
    } host_reg_e;

    // Queue control register bit positions
    localparam int unsigned QCTL_EN     = 0;
    localparam int unsigned QCTL_TXRST  = 1;
    localparam int unsigned QCTL_RXRST  = 2;
    localparam int unsigned QCTL_BITS   = 3;

    // Queue index in the generate array
    localparam int unsigned Q_TX = 0;
    localparam int unsigned Q_RX = 1;
    localparam int unsigned Q_NUM = 2;

endpackage

// File: rtl/dfifo_queue.sv
`timescale 1ns/1ps
// Single circular byte queue with a level-sensitive flush.
// Assumes push and pop are one-cycle strobes. A push to a full queue and
// a pop from an empty queue are ignored. While empty, rdata holds the
// last byte popped. While flush is high, the pointers and count stay
// cleared and both push and pop are ignored.
module dfifo_queue #(
    parameter int unsigned WIDTH = 8,
    parameter int unsigned DEPTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             push,
    input  logic [WIDTH-1:0] wdata,
    input  logic             pop,
    output logic [WIDTH-1:0] rdata,
    output logic             empty,
    output logic             full,
    output logic             half
);
    localparam int unsigned AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int unsigned CW   = $clog2(DEPTH + 1);
    localparam int unsigned HALF = DEPTH / 2;

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wr_ptr, rd_ptr;
    logic [CW-1:0]    count;
    logic [WIDTH-1:0] last_q;
    logic             do_push, do_pop;

    function automatic logic [AW-1:0] ptr_next(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign empty   = (count == '0);
    assign full    = (count == CW'(DEPTH));
    assign half    = (count >= CW'(HALF));
    assign do_push = push && !full && !flush;
    assign do_pop  = pop && !empty && !flush;
    assign rdata   = empty ? last_q : mem[rd_ptr];

    // Storage write: accepted bytes land at the write pointer
    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= wdata;
    end

    // Pointer and occupancy update, cleared by reset or flush
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= ptr_next(wr_ptr);
            if (do_pop)  rd_ptr <= ptr_next(rd_ptr);
            case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    // Last-popped byte, presented while the queue is empty
    always_ff @(posedge clk) begin
        if (!rst_n)      last_q <= '0;
        else if (do_pop) last_q <= mem[rd_ptr];
    end

    AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push && !pop && !flush) |=> full) else $error("full drop");   // R8
    AST_EMPTY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && pop && !push) |=> (empty && rdata == $past(rdata))) else $error("empty hold"); // R8
    AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> empty) else $error("flush empties");   // R12

endmodule

// File: rtl/dfifo_ctrl.sv
`timescale 1ns/1ps
// Queue control register: one enable bit and two flush bits.
// Assumes wr is a one-cycle strobe. A flush bit only takes effect while
// enable is clear; the bits themselves are stored regardless.
module dfifo_ctrl
    import dfifo_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr,
    input  logic [QCTL_BITS-1:0] wdata,
    output logic [QCTL_BITS-1:0] ctl_q,
    output logic                 enable,
    output logic                 tx_flush,
    output logic                 rx_flush
);
    // Register update: cleared at reset, loaded on host write
    always_ff @(posedge clk) begin
        if (!rst_n)  ctl_q <= '0;
        else if (wr) ctl_q <= wdata;
    end

    assign enable   = ctl_q[QCTL_EN];
    assign tx_flush = ctl_q[QCTL_TXRST] && !ctl_q[QCTL_EN];
    assign rx_flush = ctl_q[QCTL_RXRST] && !ctl_q[QCTL_EN];

endmodule

// File: rtl/dfifo_steer.sv
`timescale 1ns/1ps
// Host access steering. Decodes the host register select and routes each
// strobe either into the queues, to the controller's data or control
// port, or to the local registers. Read data is combinational.
module dfifo_steer
    import dfifo_pkg::*;
#(
    parameter int unsigned WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       host_addr,
    input  logic             host_wr,
    input  logic             host_rd,
    input  logic             enable,
    input  logic [WIDTH-1:0] q_rx_rdata,
    input  logic [WIDTH-1:0] ctl_word,
    input  logic [WIDTH-1:0] flag_word,
    input  logic [WIDTH-1:0] sc_data_rdata,
    input  logic [WIDTH-1:0] sc_ctl_rdata,
    output logic             q_tx_push,
    output logic             q_rx_pop,
    output logic             ctl_wr,
    output logic             sc_data_wr,
    output logic             sc_data_rd,
    output logic             sc_ctl_wr,
    output logic             sc_ctl_rd,
    output logic [WIDTH-1:0] host_rdata
);
    host_reg_e sel;
    assign sel = host_reg_e'(host_addr);

    // Route strobes and read data according to the register select
    always_comb begin
        q_tx_push  = 1'b0;
        q_rx_pop   = 1'b0;
        ctl_wr     = 1'b0;
        sc_data_wr = 1'b0;
        sc_data_rd = 1'b0;
        sc_ctl_wr  = 1'b0;
        sc_ctl_rd  = 1'b0;
        host_rdata = '0;
        case (sel)
            HREG_DATA: begin
                if (enable) begin
                    q_tx_push  = host_wr;
                    q_rx_pop   = host_rd;
                    host_rdata = q_rx_rdata;
                end else begin
                    sc_data_wr = host_wr;
                    sc_data_rd = host_rd;
                    host_rdata = sc_data_rdata;
                end
            end
            HREG_SCCTL: begin
                sc_ctl_wr  = host_wr;
                sc_ctl_rd  = host_rd;
                host_rdata = sc_ctl_rdata;
            end
            HREG_QCTL: begin
                ctl_wr     = host_wr;
                host_rdata = ctl_word;
            end
            default: begin
                host_rdata = flag_word;
            end
        endcase
    end

    AST_ENABLED_DATA_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && host_addr == 2'd0) |-> (!sc_data_wr && !sc_data_rd)) else $error("data quiet"); // R6
    AST_CTL_PORT_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && host_addr == 2'd1) |-> (sc_ctl_wr && !q_tx_push)) else $error("ctl pass"); // R10
    AST_QCTL_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && host_addr == 2'd2) |-> !(sc_data_wr || sc_ctl_wr || sc_data_rd || sc_ctl_rd)) else $error("qctl quiet"); // R11

endmodule

// File: rtl/dual_fifo_bridge.sv
`timescale 1ns/1ps
// Top of the dual byte FIFO bridge. Instantiates the control register,
// the host steering and one queue per direction (generate loop). Assumes
// the host issues one-cycle strobes and the controller side does likewise.
module dual_fifo_bridge
    import dfifo_pkg::*;
#(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned DEPTH  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        host_addr,
    input  logic              host_wr,
    input  logic              host_rd,
    input  logic [DATA_W-1:0] host_wdata,
    output logic [DATA_W-1:0] host_rdata,
    output logic              sc_data_wr,
    output logic              sc_data_rd,
    output logic              sc_ctl_wr,
    output logic              sc_ctl_rd,
    output logic [DATA_W-1:0] sc_wdata,
    input  logic [DATA_W-1:0] sc_data_rdata,
    input  logic [DATA_W-1:0] sc_ctl_rdata,
    input  logic              tx_pop,
    output logic [DATA_W-1:0] tx_head,
    output logic              tx_valid,
    input  logic              rx_push,
    input  logic [DATA_W-1:0] rx_wdata,
    output logic              rx_ready
);
    localparam int unsigned FLAG_PAD = DATA_W - 6;
    localparam int unsigned CTL_PAD  = DATA_W - QCTL_BITS;

    logic [QCTL_BITS-1:0] ctl_q;
    logic                 enable, tx_flush, rx_flush, ctl_wr;
    logic                 steer_tx_push, steer_rx_pop;
    logic [DATA_W-1:0]    flag_word, ctl_word;

    logic              q_flush [Q_NUM];
    logic              q_push  [Q_NUM];
    logic              q_pop   [Q_NUM];
    logic [DATA_W-1:0] q_wdata [Q_NUM];
    logic [DATA_W-1:0] q_rdata [Q_NUM];
    logic              q_empty [Q_NUM];
    logic              q_full  [Q_NUM];
    logic              q_half  [Q_NUM];

    dfifo_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr       (ctl_wr),
        .wdata    (host_wdata[QCTL_BITS-1:0]),
        .ctl_q    (ctl_q),
        .enable   (enable),
        .tx_flush (tx_flush),
        .rx_flush (rx_flush)
    );

    assign ctl_word  = {{CTL_PAD{1'b0}}, ctl_q};
    assign flag_word = {{FLAG_PAD{1'b0}},
                        q_half[Q_RX], q_full[Q_RX], q_empty[Q_RX],
                        q_half[Q_TX], q_full[Q_TX], q_empty[Q_TX]};

    dfifo_steer #(.WIDTH(DATA_W)) u_steer (
        .clk           (clk),
        .rst_n         (rst_n),
        .host_addr     (host_addr),
        .host_wr       (host_wr),
        .host_rd       (host_rd),
        .enable        (enable),
        .q_rx_rdata    (q_rdata[Q_RX]),
        .ctl_word      (ctl_word),
        .flag_word     (flag_word),
        .sc_data_rdata (sc_data_rdata),
        .sc_ctl_rdata  (sc_ctl_rdata),
        .q_tx_push     (steer_tx_push),
        .q_rx_pop      (steer_rx_pop),
        .ctl_wr        (ctl_wr),
        .sc_data_wr    (sc_data_wr),
        .sc_data_rd    (sc_data_rd),
        .sc_ctl_wr     (sc_ctl_wr),
        .sc_ctl_rd     (sc_ctl_rd),
        .host_rdata    (host_rdata)
    );

    assign sc_wdata = host_wdata;

    // Queue-side hookup: outbound fed by host, inbound fed by controller
    assign q_flush[Q_TX] = tx_flush;
    assign q_push[Q_TX]  = steer_tx_push;
    assign q_wdata[Q_TX] = host_wdata;
    assign q_pop[Q_TX]   = tx_pop;
    assign q_flush[Q_RX] = rx_flush;
    assign q_push[Q_RX]  = rx_push;
    assign q_wdata[Q_RX] = rx_wdata;
    assign q_pop[Q_RX]   = steer_rx_pop;

    for (genvar gi = 0; gi < Q_NUM; gi++) begin : g_queue
        dfifo_queue #(.WIDTH(DATA_W), .DEPTH(DEPTH)) u_queue (
            .clk   (clk),
            .rst_n (rst_n),
            .flush (q_flush[gi]),
            .push  (q_push[gi]),
            .wdata (q_wdata[gi]),
            .pop   (q_pop[gi]),
            .rdata (q_rdata[gi]),
            .empty (q_empty[gi]),
            .full  (q_full[gi]),
            .half  (q_half[gi])
        );
    end

    assign tx_head  = q_rdata[Q_TX];
    assign tx_valid = !q_empty[Q_TX];
    assign rx_ready = !q_full[Q_RX];

    AST_GATED_TX: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && !q_empty[Q_TX] && !tx_pop) |=> !q_empty[Q_TX]) else $error("gated tx"); // R4
    AST_GATED_RX: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && !q_empty[Q_RX] && !steer_rx_pop) |=> !q_empty[Q_RX]) else $error("gated rx"); // R4

endmodule

// File: tb/dual_fifo_bridge_bench.sv
`timescale 1ns/1ps
// Directed bench: one task per scenario, each checking its own results.
module dual_fifo_bridge_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] host_addr = '0;
    logic       host_wr = 1'b0, host_rd = 1'b0;
    logic [7:0] host_wdata = '0, host_rdata;
    logic       sc_data_wr, sc_data_rd, sc_ctl_wr, sc_ctl_rd;
    logic [7:0] sc_wdata;
    logic [7:0] sc_data_rdata = 8'h3C, sc_ctl_rdata = 8'hC5;
    logic       tx_pop = 1'b0;
    logic [7:0] tx_head;
    logic       tx_valid;
    logic       rx_push = 1'b0;
    logic [7:0] rx_wdata = '0;
    logic       rx_ready;

    int checks = 0;
    int errors = 0;
    logic [3:0] snap;      // {sc_data_wr, sc_data_rd, sc_ctl_wr, sc_ctl_rd}
    logic [7:0] snap_wd, rd_val;

    always #10 clk = ~clk;

    dual_fifo_bridge u_dual_fifo_bridge (.*);

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic host_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        host_addr = a; host_wdata = d; host_wr = 1'b1;
        #1;
        snap = {sc_data_wr, sc_data_rd, sc_ctl_wr, sc_ctl_rd};
        snap_wd = sc_wdata;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic host_read(input logic [1:0] a);
        @(negedge clk);
        host_addr = a; host_rd = 1'b1;
        #1;
        rd_val = host_rdata;
        snap = {sc_data_wr, sc_data_rd, sc_ctl_wr, sc_ctl_rd};
        @(negedge clk);
        host_rd = 1'b0;
    endtask

    task automatic flags(output logic [7:0] f);
        @(negedge clk);
        host_addr = 2'd3;
        #1;
        f = host_rdata;
    endtask

    task automatic rx_put(input logic [7:0] d);
        @(negedge clk);
        rx_push = 1'b1; rx_wdata = d;
        @(negedge clk);
        rx_push = 1'b0;
    endtask

    task automatic tx_take(input logic [7:0] exp, input string tag);
        @(negedge clk);
        check(tx_valid && tx_head == exp, tag, {tx_valid, tx_head}, {1'b1, exp});
        tx_pop = 1'b1;
        @(negedge clk);
        tx_pop = 1'b0;
    endtask

    task automatic t_reset();
        logic [7:0] f;
        host_read(2'd2);
        check(rd_val == 8'h00, "R1 ctl after reset", rd_val, 8'h00);
        flags(f);
        check(f == 8'h09, "R1 flags after reset", f, 8'h09);
    endtask

    task automatic t_passthrough();
        logic [7:0] f;
        host_write(2'd0, 8'h5A);
        check(snap == 4'b1000 && snap_wd == 8'h5A, "R9 disabled write strobe", {snap, snap_wd}, {4'b1000, 8'h5A});
        host_read(2'd0);
        check(snap == 4'b0100 && rd_val == 8'h3C, "R9 disabled read", {snap, rd_val}, {4'b0100, 8'h3C});
        flags(f);
        check(f == 8'h09, "R9 queues untouched", f, 8'h09);
        host_write(2'd3, 8'hFF);
        flags(f);
        check(f == 8'h09, "R5 flag write ignored", f, 8'h09);
    endtask

    task automatic t_ctl_port();
        logic [7:0] f;
        host_write(2'd1, 8'h81);
        check(snap == 4'b0010 && snap_wd == 8'h81, "R10 ctl write disabled", {snap, snap_wd}, {4'b0010, 8'h81});
        host_write(2'd2, 8'h01);
        check(snap == 4'b0000, "R11 enable write quiet", snap, 0);
        host_write(2'd1, 8'h42);
        check(snap == 4'b0010, "R10 ctl write enabled", snap, 4'b0010);
        host_read(2'd1);
        check(snap == 4'b0001 && rd_val == 8'hC5, "R10 ctl read enabled", {snap, rd_val}, {4'b0001, 8'hC5});
        flags(f);
        check(f == 8'h09, "R10 queues untouched", f, 8'h09);
    endtask

    task automatic t_tx_path();
        logic [7:0] f;
        host_write(2'd0, 8'hA1);
        check(snap == 4'b0000, "R6 no controller strobe", snap, 0);
        host_write(2'd0, 8'hA2);
        host_write(2'd0, 8'hA3);
        flags(f);
        check(f[0] == 1'b0, "R6 outbound not empty", f, 8'h08);
        tx_take(8'hA1, "R6 order 1");
        tx_take(8'hA2, "R6 order 2");
        tx_take(8'hA3, "R6 order 3");
        @(negedge clk);
        check(!tx_valid, "R6 drained", tx_valid, 0);
    endtask

    task automatic t_rx_path();
        rx_put(8'hB1); rx_put(8'hB2); rx_put(8'hB3);
        host_read(2'd0);
        check(rd_val == 8'hB1 && snap == 4'b0000, "R7 order 1", {snap, rd_val}, 8'hB1);
        host_read(2'd0);
        check(rd_val == 8'hB2, "R7 order 2", rd_val, 8'hB2);
        host_read(2'd0);
        check(rd_val == 8'hB3, "R7 order 3", rd_val, 8'hB3);
        host_read(2'd0);
        check(rd_val == 8'hB3, "R8 empty read holds last", rd_val, 8'hB3);
        rx_put(8'h99);
        host_read(2'd0);
        check(rd_val == 8'h99, "R8 pointers unchanged", rd_val, 8'h99);
    endtask

    task automatic t_levels();
        logic [7:0] f;
        for (int i = 0; i < 16; i++) begin
            host_write(2'd0, 8'h10 + 8'(i));
            if (i == 6) begin
                flags(f);
                check(f[2:0] == 3'b000, "R5 seven not half", f, 8'h08);
            end
            if (i == 7) begin
                flags(f);
                check(f[2:0] == 3'b100, "R5 eight is half", f, 8'h0C);
            end
        end
        flags(f);
        check(f == 8'h0E, "R5 sixteen full", f, 8'h0E);
        host_write(2'd0, 8'hEE);
        flags(f);
        check(f == 8'h0E, "R8 overflow still full", f, 8'h0E);
        for (int i = 0; i < 16; i++) tx_take(8'h10 + 8'(i), "R8 overflow dropped");
        @(negedge clk);
        check(!tx_valid, "R8 no extra byte", tx_valid, 0);
    endtask

    task automatic t_gated();
        logic [7:0] f;
        host_write(2'd0, 8'hC1);
        host_write(2'd0, 8'hC2);
        rx_put(8'h77);
        host_write(2'd2, 8'h07);
        check(snap == 4'b0000, "R11 flush write quiet", snap, 0);
        @(negedge clk); @(negedge clk);
        flags(f);
        check(f[0] == 1'b0 && f[3] == 1'b0, "R4 flush ignored while enabled", f, 8'h00);
        host_write(2'd2, 8'h02);
        check(snap == 4'b0000, "R11 flush write quiet 2", snap, 0);
        @(negedge clk);
        flags(f);
        check(f[0] == 1'b1 && f[3] == 1'b0, "R2 tx flush only", f, 8'h01);
        host_write(2'd2, 8'h04);
        @(negedge clk);
        flags(f);
        check(f[3] == 1'b1, "R3 rx flush", f, 8'h09);
        rx_put(8'h55);
        flags(f);
        check(f[3] == 1'b1, "R12 held flush ignores push", f, 8'h09);
        host_write(2'd2, 8'h00);
        rx_put(8'h66);
        flags(f);
        check(f == 8'h01, "R12 accepts after clear", f, 8'h01);
        host_write(2'd2, 8'h01);
        host_read(2'd0);
        check(rd_val == 8'h66, "R3 fresh data after flush", rd_val, 8'h66);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_passthrough();
        t_ctl_port();
        t_tx_path();
        t_rx_path();
        t_levels();
        t_gated();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule